// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode sequencer of a single-wire LIN physical-layer transceiver that also carries an on-chip supply regulator. It follows the supply monitors, the controller-side enable, standby and transmit-data pins, and wake events from a separate detector. From these it chooses one of five operating states: power-off, standby, normal-slope, low-slope and sleep. It then drives the regulator enable, transmitter enable, slope select, bus termination select, the inhibit output and the receive-data pin. The analog front end (slope shaping, comparators, thresholds, regulator) sits outside the block. Supply-monitor flags and wake events arrive here as digital levels.

The enable, standby and transmit-data pins pass through a synchronizer before their edges are detected. The TxD level seen at a rising enable edge picks the slope mode. In low-slope mode the transmitter stays off until TxD has been high once, so that entering the mode never puts a dominant level on the bus. A dominant-timeout counter turns the transmitter off when TxD stays low for too long and releases it when TxD goes high again. Supply flags, wake events and the receiver output are registered once. Every output is decoded from registered state only.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the state code is power-off (mode_code 0), with reg_en, tx_en, term_res and inh_high low and rxd_out high. Once bat_por_low and bat_uv are both low, the state becomes standby (code 1) with reg_en high.
- R2: While bat_por_low is high the state is forced to power-off (code 0) from any state, with reg_en and tx_en low.
- R3: In standby, a rising edge on en_pin while txd_pin is high, bat_uv is low and reg_uv is low selects normal-slope (code 2). In that state tx_en is 1, term_res is 1 (resistor termination) and slope_low is 0.
- R4: The same edge while txd_pin is low selects low-slope (code 3) with slope_low 1 and term_res 1. tx_en stays 0 until txd_pin has been seen high, and after that it follows the normal rule.
- R5: A rising edge on en_pin in standby is ignored while reg_uv or bat_uv is high.
- R6: A falling edge on en_pin in either normal state leads to sleep (code 4) when stb_pin is low and bat_uv is low. It leads to standby when stb_pin is high or bat_uv is high.
- R7: inh_high is 1 in a normal state only if stb_pin was high on the standby-to-normal transition. Otherwise it is 0 (floating), and it is always 0 in standby, sleep and power-off.
- R8: In sleep, reg_en, tx_en and term_res are 0 (current-source termination) and rxd_out is 1. In standby, reg_en is 1 and tx_en and term_res are 0.
- R9: A pulse on wake_local or wake_bus in sleep moves the state to standby.
- R10: In standby, rxd_out is 1 after power-up or a local wake. After a bus wake, seen either in sleep or in standby, rxd_out is 0 until a normal state is entered.
- R11: tx_en is 0 whenever bat_uv is high, even in a normal state.
- R12: When txd_pin stays low for DOM_CYCLES clock cycles, tx_en goes to 0. It returns to 1 once txd_pin is high again.
- R13: In a normal state rxd_out follows rx_bus (0 means dominant), with a one-cycle register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Enable pin from the protocol controller |
| stb_pin | input | 1 | Standby control pin |
| txd_pin | input | 1 | Transmit data, low means dominant |
| wake_local | input | 1 | Local wake event from the wake-pin detector |
| wake_bus | input | 1 | Remote wake event from the bus wake detector |
| bat_por_low | input | 1 | Battery supply below its power-on-reset low level |
| bat_uv | input | 1 | Battery supply below its undervoltage threshold |
| reg_uv | input | 1 | Regulator output below its undervoltage threshold |
| rx_bus | input | 1 | Receiver comparator output, low means dominant |
| mode_code | output | 3 | 0 off, 1 standby, 2 normal-slope, 3 low-slope, 4 sleep |
| reg_en | output | 1 | Regulator enable |
| tx_en | output | 1 | Transmitter enable |
| slope_low | output | 1 | Reduced slew-rate select |
| term_res | output | 1 | 1 selects resistor termination, 0 the current source |
| inh_high | output | 1 | 1 drives the inhibit output high, 0 leaves it floating |
| rxd_out | output | 1 | Receive-data pin level |

## Verification
A wrong state code shows at once on mode_code. It also shows within the same cycle on reg_en and term_res, which are decoded only from the state. Flag bits that go wrong are harder to see. A stale low-slope arming bit stays hidden until the next low-slope entry, where tx_en rises while TxD is still low. A stale bus-wake flag stays hidden until standby, where rxd_out reads low after a local wake. A stale inhibit flag shows up only in the next normal state. The bench therefore drives each of these flags through both of its transitions and samples the outputs a few cycles after each stimulus.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_STBY  = 3'd1,
    M_NORM  = 3'd2,
    M_LOWS  = 3'd3,
    M_SLEEP = 3'd4
  } lin_mode_e;

  typedef struct packed {
    logic reg_en;
    logic tx_en;
    logic slope_low;
    logic term_res;
    logic inh_high;
    logic rxd;
  } lin_drive_t;

  function automatic logic f_is_normal(lin_mode_e m);
    return (m == M_NORM) || (m == M_LOWS);
  endfunction

  function automatic logic f_reg_on(lin_mode_e m);
    return (m == M_STBY) || f_is_normal(m);
  endfunction

  function automatic logic f_tx_allowed(lin_mode_e m, logic armed,
                                        logic uv, logic tmo);
    logic mode_ok;
    mode_ok = (m == M_NORM) || ((m == M_LOWS) && armed);
    return mode_ok && !uv && !tmo;
  endfunction

  function automatic logic f_rxd(lin_mode_e m, logic bus_woken, logic rx);
    logic r;
    case (m)
      M_NORM, M_LOWS: r = rx;
      M_STBY:         r = !bus_woken;
      default:        r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lin_dom_timer.sv
module lin_dom_timer #(
  parameter int DOM_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s,
  output logic timeout
);
  localparam int CW = $clog2(DOM_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DOM_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (txd_s) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign timeout = (cnt == LIMIT);

  // R12: a high TxD releases the timeout on the next cycle
  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    txd_s |=> !timeout);
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_s,
  input  logic      stb_s,
  input  logic      txd_s,
  input  logic      por_q,
  input  logic      bat_uv_q,
  input  logic      reg_uv_q,
  input  logic      wl_q,
  input  logic      wb_q,
  output lin_mode_e mode,
  output logic      lows_armed,
  output logic      inh_flag,
  output logic      bus_woken,
  output logic      en_rise,
  output logic      en_fall
);
  logic      en_prev;
  lin_mode_e nxt;

  assign en_rise = en_s && !en_prev;
  assign en_fall = !en_s && en_prev;

  always_comb begin
    nxt = mode;
    if (por_q) nxt = M_OFF;
    else begin
      case (mode)
        M_OFF:   if (!bat_uv_q) nxt = M_STBY;
        M_STBY:  if (en_rise && !bat_uv_q && !reg_uv_q)
                   nxt = txd_s ? M_NORM : M_LOWS;
        M_NORM, M_LOWS:
                 if (en_fall)
                   nxt = (!stb_s && !bat_uv_q) ? M_SLEEP : M_STBY;
        M_SLEEP: if (wl_q || wb_q) nxt = M_STBY;
        default: nxt = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_OFF;
      en_prev    <= 1'b0;
      lows_armed <= 1'b0;
      inh_flag   <= 1'b0;
      bus_woken  <= 1'b0;
    end else begin
      mode    <= nxt;
      en_prev <= en_s;
      if (nxt == M_LOWS && mode != M_LOWS) lows_armed <= 1'b0;
      else if (mode == M_LOWS && txd_s)    lows_armed <= 1'b1;
      if (mode == M_STBY && f_is_normal(nxt)) inh_flag <= stb_s;
      if (f_is_normal(nxt) || nxt == M_OFF)   bus_woken <= 1'b0;
      else if ((mode == M_SLEEP || mode == M_STBY) && wb_q) bus_woken <= 1'b1;
      else if (mode == M_SLEEP && wl_q)       bus_woken <= 1'b0;
    end
  end

  // R2: battery POR forces power-off
  a_r2_por_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    por_q |=> (mode == M_OFF));
  // R9: wake events leave sleep
  a_r9_wake_leaves_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && (wl_q || wb_q) && !por_q) |=> (mode == M_STBY));
  // R4: low-slope is entered unarmed
  a_r4_enter_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_LOWS) |=> !(mode == M_LOWS && lows_armed));
endmodule

// File: rtl/lin_out_drive.sv
module lin_out_drive
  import lin_mode_pkg::*;
(
  input  lin_mode_e  mode,
  input  logic       lows_armed,
  input  logic       inh_flag,
  input  logic       bus_woken,
  input  logic       bat_uv_q,
  input  logic       dom_tmo,
  input  logic       rx_q,
  output lin_drive_t drv
);
  always_comb begin
    drv.reg_en    = f_reg_on(mode);
    drv.tx_en     = f_tx_allowed(mode, lows_armed, bat_uv_q, dom_tmo);
    drv.slope_low = (mode == M_LOWS);
    drv.term_res  = f_is_normal(mode);
    drv.inh_high  = f_is_normal(mode) && inh_flag;
    drv.rxd       = f_rxd(mode, bus_woken, rx_q);
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DOM_CYCLES  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       stb_pin,
  input  logic       txd_pin,
  input  logic       wake_local,
  input  logic       wake_bus,
  input  logic       bat_por_low,
  input  logic       bat_uv,
  input  logic       reg_uv,
  input  logic       rx_bus,
  output logic [2:0] mode_code,
  output logic       reg_en,
  output logic       tx_en,
  output logic       slope_low,
  output logic       term_res,
  output logic       inh_high,
  output logic       rxd_out
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic en_s, stb_s, txd_s;
  logic por_q, bat_uv_q, reg_uv_q, wl_q, wb_q, rx_q;
  logic dom_tmo, lows_armed, inh_flag, bus_woken, en_rise, en_fall;
  lin_mode_e  mode;
  lin_drive_t drv;

  lin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({txd_pin, stb_pin, en_pin}), .q(pins_s));

  assign {txd_s, stb_s, en_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b1; bat_uv_q <= 1'b1; reg_uv_q <= 1'b1;
      wl_q  <= 1'b0; wb_q     <= 1'b0; rx_q     <= 1'b1;
    end else begin
      por_q <= bat_por_low; bat_uv_q <= bat_uv; reg_uv_q <= reg_uv;
      wl_q  <= wake_local;  wb_q     <= wake_bus; rx_q   <= rx_bus;
    end
  end

  lin_dom_timer #(.DOM_CYCLES(DOM_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .timeout(dom_tmo));

  lin_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .stb_s(stb_s), .txd_s(txd_s),
    .por_q(por_q), .bat_uv_q(bat_uv_q), .reg_uv_q(reg_uv_q),
    .wl_q(wl_q), .wb_q(wb_q), .mode(mode), .lows_armed(lows_armed),
    .inh_flag(inh_flag), .bus_woken(bus_woken),
    .en_rise(en_rise), .en_fall(en_fall));

  lin_out_drive u_drv (
    .mode(mode), .lows_armed(lows_armed), .inh_flag(inh_flag),
    .bus_woken(bus_woken), .bat_uv_q(bat_uv_q), .dom_tmo(dom_tmo),
    .rx_q(rx_q), .drv(drv));

  assign mode_code = mode;
  assign reg_en    = drv.reg_en;
  assign tx_en     = drv.tx_en;
  assign slope_low = drv.slope_low;
  assign term_res  = drv.term_res;
  assign inh_high  = drv.inh_high;
  assign rxd_out   = drv.rxd;

  // R11: battery undervoltage keeps the transmitter off
  a_r11_uv_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    bat_uv_q |-> !tx_en);
  // R8: sleep turns off the supply, the driver and the resistor
  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd4) |-> (!reg_en && !tx_en && !term_res && rxd_out));
  // R7: inhibit floats outside the normal states
  a_r7_inh_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 3'd2 && mode_code != 3'd3) |-> !inh_high);
  // R4: no transmission in the cycle low-slope is entered
  a_r4_low_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3 && $past(mode_code) != 3'd3) |-> !tx_en);
endmodule

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
  localparam int DOM = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, stb_pin = 0, txd_pin = 1, wake_local = 0, wake_bus = 0;
  logic bat_por_low = 1, bat_uv = 1, reg_uv = 1, rx_bus = 1;
  logic [2:0] mode_code;
  logic reg_en, tx_en, slope_low, term_res, inh_high, rxd_out;

  always #5 clk = ~clk;

  lin_mode_ctrl #(.SYNC_STAGES(2), .DOM_CYCLES(DOM)) u_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .stb_pin(stb_pin),
    .txd_pin(txd_pin), .wake_local(wake_local), .wake_bus(wake_bus),
    .bat_por_low(bat_por_low), .bat_uv(bat_uv), .reg_uv(reg_uv),
    .rx_bus(rx_bus), .mode_code(mode_code), .reg_en(reg_en), .tx_en(tx_en),
    .slope_low(slope_low), .term_res(term_res), .inh_high(inh_high),
    .rxd_out(rxd_out));

  typedef struct {
    logic [8:0] want;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // {mode[2:0], reg_en, tx_en, slope_low, term_res, inh_high, rxd}
  function automatic logic [8:0] pack(int m, bit rg, bit tx, bit sl,
                                      bit tr, bit ih, bit rx);
    return {3'(m), rg, tx, sl, tr, ih, rx};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: wait for settling, then queue the expectation
  task automatic expect_out(int m, bit rg, bit tx, bit sl, bit tr, bit ih,
                            bit rx, string tag);
    item_t it;
    cyc(5);
    it.want = pack(m, rg, tx, sl, tr, ih, rx);
    it.tag  = tag;
    q.push_back(it);
  endtask

  // Monitor: compare queued expectations after the sampling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [8:0] got;
        it  = q.pop_front();
        got = {mode_code, reg_en, tx_en, slope_low, term_res, inh_high, rxd_out};
        n_chk++;
        if (got !== it.want) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.tag, got, it.want);
        end
      end
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    expect_out(0, 0, 0, 0, 0, 0, 1, "R1 reset off");
    bat_por_low = 0; bat_uv = 0; reg_uv = 0;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R1 power-up standby");
    reg_uv = 1; en_pin = 1;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R5 enable ignored under regulator uv");
    en_pin = 0; cyc(3); reg_uv = 0; cyc(2);
    stb_pin = 0; txd_pin = 1; en_pin = 1;
    expect_out(2, 1, 1, 0, 1, 0, 1, "R3 normal slope entry");
    rx_bus = 0;
    expect_out(2, 1, 1, 0, 1, 0, 0, "R13 rxd dominant");
    rx_bus = 1;
    expect_out(2, 1, 1, 0, 1, 0, 1, "R13 rxd recessive");
    txd_pin = 0;
    expect_out(2, 1, 1, 0, 1, 0, 1, "R12 short dominant keeps tx");
    cyc(DOM);
    expect_out(2, 1, 0, 0, 1, 0, 1, "R12 dominant timeout");
    txd_pin = 1;
    expect_out(2, 1, 1, 0, 1, 0, 1, "R12 release on txd high");
    bat_uv = 1;
    expect_out(2, 1, 0, 0, 1, 0, 1, "R11 uv forces tx off");
    en_pin = 0;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R6 fall under uv gives standby");
    bat_uv = 0; cyc(2);
    stb_pin = 1; txd_pin = 0; en_pin = 1;
    expect_out(3, 1, 0, 1, 1, 1, 1, "R4 low slope entry held off R7 inh");
    expect_out(3, 1, 0, 1, 1, 1, 1, "R4 still held while txd low");
    txd_pin = 1;
    expect_out(3, 1, 1, 1, 1, 1, 1, "R4 armed after txd high");
    txd_pin = 0;
    expect_out(3, 1, 1, 1, 1, 1, 1, "R4 dominant after arming");
    txd_pin = 1; cyc(2);
    en_pin = 0;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R6 fall with stb high gives standby R7");
    stb_pin = 0; en_pin = 1;
    expect_out(2, 1, 1, 0, 1, 0, 1, "R7 inh floats when stb low at entry");
    en_pin = 0;
    expect_out(4, 0, 0, 0, 0, 0, 1, "R6 sleep R8 outputs");
    rx_bus = 0;
    expect_out(4, 0, 0, 0, 0, 0, 1, "R8 sleep rxd held high");
    rx_bus = 1;
    wake_local = 1; cyc(1); wake_local = 0;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R9 local wake R10 rxd high");
    en_pin = 1; cyc(5); en_pin = 0;
    expect_out(4, 0, 0, 0, 0, 0, 1, "R6 back to sleep");
    wake_bus = 1; cyc(1); wake_bus = 0;
    expect_out(1, 1, 0, 0, 0, 0, 0, "R9 bus wake R10 rxd low");
    expect_out(1, 1, 0, 0, 0, 0, 0, "R10 rxd low held");
    en_pin = 1;
    expect_out(2, 1, 1, 0, 1, 0, 1, "R10 flag cleared in normal");
    stb_pin = 1; en_pin = 0;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R10 standby rxd high after normal");
    wake_bus = 1; cyc(1); wake_bus = 0;
    expect_out(1, 1, 0, 0, 0, 0, 0, "R10 bus wake seen in standby");
    en_pin = 1;
    expect_out(2, 1, 1, 0, 1, 1, 1, "R7 inh high stb at entry");
    bat_por_low = 1; bat_uv = 1;
    expect_out(0, 0, 0, 0, 0, 0, 1, "R2 por forces off");
    bat_por_low = 0; bat_uv = 0;
    expect_out(1, 1, 0, 0, 0, 0, 1, "R1 repower standby");
    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule